// File: doc/BRIEF.md
# Command-Complete Interrupt Status Unit

This unit keeps one completion flag for each user command channel of a management-bus controller. There are two channels by default. When a PHY read or write that was queued on a channel finishes, the channel raises a one-cycle `done` pulse. The unit then sets that channel's flag. Software sees the flags through a 32-bit register port in two ways:
- a raw view, which shows every flag;
- a masked view, which shows only the flags whose channel is enabled.

Software clears a flag by writing a one to it. It can do this through either view, because both views act on the same flags.

A small control register holds a test-enable bit. While that bit is set, writing a one to a flag sets the flag instead of clearing it, so software can inject interrupts without real bus traffic. Channel enables are changed through two registers, one that sets enables and one that clears them, so that no read-modify-write is needed. A single interrupt line is driven from a register. It is high one cycle after any masked flag is high.

The register port is a plain single-cycle port with no handshake. A write takes effect on the clock edge where `reg_wr` is high. `reg_rdata` shows, combinationally, the register at `reg_addr` as it stands before that edge. No completion stream carries payload, so no valid/ready pair applies and no back-pressure exists: each `done` pulse is recorded in the cycle it arrives.

Top module: `cmdint_status_unit`

## Requirements
- R1: Flag bit 1 belongs to channel 1 and bit 0 to channel 0. In the raw register (byte offset 0x00) and the masked register (0x04), bits 31..2 always read 0.
- R2: A high `cmd_done[i]` sets flag i at the next clock edge, and the raw register shows it from the following cycle.
- R3: With test mode off, a write to offset 0x00 clears every flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R4: With test mode on, a write to 0x00 or 0x04 sets every flag whose data bit is 1, and leaves the rest unchanged.
- R5: The masked register reads as raw flags AND channel enable mask.
- R6: A write to 0x04 acts on the underlying flags exactly as a write to 0x00 does (clear, or set in test mode), whatever the mask holds.
- R7: Writing 1s to offset 0x08 sets mask bits, and writing 1s to 0x0C clears them. Both offsets read back the current mask.
- R8: While reset is asserted and right after it, all flags, the mask, the test bit and `irq` are 0.
- R9: When a `cmd_done` pulse and a clearing write hit the same flag in one cycle, the flag ends up 1.
- R10: `irq` in a cycle equals the OR of the masked flags in the previous cycle.
- R11: The control register at 0x10 holds the test-enable bit in bit 0. Bit 0 is read/write and bits 31..1 read 0.
- R12: Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_done | input | NCH | One-cycle completion pulse per channel |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The first stimulus is directed. It covers:
- completions arriving alone, with the mask both closed and open, which separates the raw view from the masked view and sets the `irq` lag;
- clears through each view with per-bit data patterns, which separates the two channels and shows that 0-bits are ignored;
- a completion and a clear on the same flag in one cycle, which shows which one wins;
- test-mode writes, which must set flags instead of clearing them.

A long random mix of completions, writes to every offset (including unmapped ones), and toggling of the test bit then runs. A behavioural model checks every cycle, which finds wrong priorities and wrong mask or decode routing that the directed cases do not reach.

// File: rtl/cmdint_pkg.sv
package cmdint_pkg;

  // Register byte offsets on the status port
  localparam int unsigned OFS_RAW    = 'h00;
  localparam int unsigned OFS_MASKED = 'h04;
  localparam int unsigned OFS_MSET   = 'h08;
  localparam int unsigned OFS_MCLR   = 'h0C;
  localparam int unsigned OFS_CTRL   = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASKED,
    SEL_MSET,
    SEL_MCLR,
    SEL_CTRL
  } reg_sel_e;

  typedef struct packed {
    logic status_wr;  // write to raw or masked view
    logic mset_wr;
    logic mclr_wr;
    logic ctrl_wr;
  } wr_strobe_t;

endpackage

// File: rtl/cmdint_regdec.sv
module cmdint_regdec
  import cmdint_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output wr_strobe_t        strb
);

  always_comb begin
    sel = SEL_NONE;
    if (int'(addr) == OFS_RAW)         sel = SEL_RAW;
    else if (int'(addr) == OFS_MASKED) sel = SEL_MASKED;
    else if (int'(addr) == OFS_MSET)   sel = SEL_MSET;
    else if (int'(addr) == OFS_MCLR)   sel = SEL_MCLR;
    else if (int'(addr) == OFS_CTRL)   sel = SEL_CTRL;
  end

  always_comb begin
    strb           = '0;
    strb.status_wr = wr && (sel == SEL_RAW || sel == SEL_MASKED);
    strb.mset_wr   = wr && (sel == SEL_MSET);
    strb.mclr_wr   = wr && (sel == SEL_MCLR);
    strb.ctrl_wr   = wr && (sel == SEL_CTRL);
  end

  always_comb begin
    assert ($countones({strb.status_wr, strb.mset_wr, strb.mclr_wr, strb.ctrl_wr}) <= 1)
      else $error("AST_ONE_STROBE");  // R12
  end

endmodule

// File: rtl/cmdint_flag_bank.sv
module cmdint_flag_bank #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done,
  input  logic           status_wr,
  input  logic           test_en,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] flags
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic nxt;

    always_comb begin
      nxt = flags[i];
      if (status_wr && wbits[i]) nxt = test_en;
      if (done[i])               nxt = 1'b1;  // new event has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= nxt;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> flags[i]);  // R2
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && wbits[i] && !test_en && !done[i]) |=> !flags[i]);  // R3
    AST_TEST_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && wbits[i] && test_en) |=> flags[i]);  // R4
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!done[i] && !(status_wr && wbits[i])) |=> $stable(flags[i]));  // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && status_wr && wbits[i]) |=> flags[i]);  // R9
  end

endmodule

// File: rtl/cmdint_mask_ctl.sv
module cmdint_mask_ctl #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_wr,
  input  logic           clr_wr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (set_wr) mask <= mask | wbits;
    else if (clr_wr) mask <= mask & ~wbits;
  end

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask & $past(mask)) == $past(mask)));  // R7
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mask & ~$past(mask)) == '0));  // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(mask));  // R7

endmodule

// File: rtl/cmdint_status_unit.sv
module cmdint_status_unit
  import cmdint_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmd_done,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int PAD_W = DATA_W - NCH;

  reg_sel_e       sel;
  wr_strobe_t     strb;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] mask_q;
  logic           test_en_q;
  logic [NCH-1:0] wbits;

  assign wbits = reg_wdata[NCH-1:0];

  cmdint_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .wr   (reg_wr),
    .sel  (sel),
    .strb (strb)
  );

  cmdint_flag_bank #(.NCH(NCH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (cmd_done),
    .status_wr (strb.status_wr),
    .test_en   (test_en_q),
    .wbits     (wbits),
    .flags     (flag_q)
  );

  cmdint_mask_ctl #(.NCH(NCH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (strb.mset_wr),
    .clr_wr (strb.mclr_wr),
    .wbits  (wbits),
    .mask   (mask_q)
  );

  // Local control register: bit 0 is the test enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            test_en_q <= 1'b0;
    else if (strb.ctrl_wr) test_en_q <= reg_wdata[0];
  end

  // Registered interrupt request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_q & mask_q);
  end

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_RAW:           reg_rdata = {{PAD_W{1'b0}}, flag_q};
      SEL_MASKED:        reg_rdata = {{PAD_W{1'b0}}, flag_q & mask_q};
      SEL_MSET, SEL_MCLR: reg_rdata = {{PAD_W{1'b0}}, mask_q};
      SEL_CTRL:          reg_rdata = {{(DATA_W-1){1'b0}}, test_en_q};
      default:           reg_rdata = '0;
    endcase
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RAW || sel == SEL_MASKED) |-> (reg_rdata[DATA_W-1:NCH] == '0));  // R1
  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MASKED) |-> ((reg_rdata[NCH-1:0] & ~mask_q) == '0));  // R5
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flag_q & mask_q))));  // R10
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (reg_rdata[DATA_W-1:1] == '0));  // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0));  // R12

endmodule

// File: tb/cmdint_status_unit_bench.sv
module cmdint_status_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_done = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  cmdint_status_unit u_cmdint_status_unit (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  // Reference model state
  int m_flags = 0, m_mask = 0, m_ten = 0, m_irq = 0;

  function automatic int exp_read(int a);
    case (a)
      'h00: return m_flags;            // R1 R2 R3
      'h04: return m_flags & m_mask;   // R5
      'h08, 'h0C: return m_mask;       // R7
      'h10: return m_ten;              // R11
      default: return 0;               // R12
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      'h00: return "R2/R3";
      'h04: return "R5";
      'h08, 'h0C: return "R7";
      'h10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic compare(string tag);
    int e;
    e = exp_read(int'(reg_addr));
    vectors++;
    if (reg_rdata !== 32'(e)) begin
      errors++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, reg_addr, reg_rdata, e);
    end
    vectors++;
    if (irq !== m_irq[0]) begin
      errors++;
      $display("FAIL R10 irq actual=%0b expected=%0d", irq, m_irq);
    end
  endtask

  // One cycle: check at negedge, drive inputs, advance model
  task automatic step(input logic [1:0] d, input logic w, input int a, input int wd);
    int nf, nm, nt;
    compare(req_of(int'(reg_addr)));
    cmd_done = d; reg_wr = w; reg_addr = 5'(a); reg_wdata = 32'(wd);
    nf = m_flags; nm = m_mask; nt = m_ten;
    if (w) begin
      if (a == 'h00 || a == 'h04) begin              // R3 R4 R6
        if (m_ten != 0) nf = nf | (wd & 3);
        else            nf = nf & ~(wd & 3);
      end
      if (a == 'h08) nm = nm | (wd & 3);              // R7
      if (a == 'h0C) nm = nm & ~(wd & 3);
      if (a == 'h10) nt = wd & 1;                     // R11
    end
    nf = nf | int'(d);                                // R2 R9: event wins
    m_irq = ((m_flags & m_mask) != 0) ? 1 : 0;        // R10
    m_flags = nf; m_mask = nm; m_ten = nt;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: reset state, including under activity
    cmd_done = 2'b11; reg_wr = 1'b1; reg_addr = 5'h08; reg_wdata = 32'hFFFF_FFFF;
    repeat (3) begin
      compare("R8");
      @(negedge clk);
    end
    cmd_done = '0; reg_wr = 1'b0; reg_addr = 5'h00;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R8");

    // R2, R1: completion on channel 0 then channel 1, mask closed
    step(2'b01, 0, 'h00, 0);
    step(2'b00, 0, 'h00, 0);
    step(2'b10, 0, 'h04, 0);
    step(2'b00, 0, 'h00, 0);
    // R7: open channel 1 only, read back via both offsets; R5 masked view, R10 irq
    step(2'b00, 1, 'h08, 'hFFFF_FFFE);
    step(2'b00, 0, 'h0C, 0);
    step(2'b00, 0, 'h04, 0);
    step(2'b00, 0, 'h04, 0);
    // R3: clear bit 0 only via raw view, bit 1 unchanged
    step(2'b00, 1, 'h00, 1);
    step(2'b00, 0, 'h00, 0);
    // R6: clear bit 1 through masked view
    step(2'b00, 1, 'h04, 2);
    step(2'b00, 0, 'h00, 0);
    // R6: masked-view clear of a channel whose mask is off
    step(2'b01, 0, 'h00, 0);
    step(2'b00, 1, 'h04, 1);
    step(2'b00, 0, 'h00, 0);
    // R9: completion and clear together
    step(2'b10, 0, 'h00, 0);
    step(2'b10, 1, 'h00, 3);
    step(2'b00, 0, 'h00, 0);
    // R11, R4: test mode sets through both views
    step(2'b00, 1, 'h10, 'hFFFF_FFFF);
    step(2'b00, 0, 'h10, 0);
    step(2'b00, 1, 'h00, 0);
    step(2'b00, 1, 'h00, 1);
    step(2'b00, 1, 'h04, 2);
    step(2'b00, 0, 'h00, 0);
    step(2'b00, 1, 'h10, 0);
    // R12: unmapped writes have no effect
    step(2'b00, 1, 'h14, 'hFFFF_FFFF);
    step(2'b00, 1, 'h1C, 'hFFFF_FFFF);
    step(2'b00, 0, 'h00, 0);
    step(2'b00, 0, 'h08, 0);
    step(2'b00, 1, 'h0C, 3);
    step(2'b00, 0, 'h08, 0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int a, sel;
      sel = int'($urandom_range(0, 7));
      a = (sel < 5) ? sel * 4 : ((sel == 5) ? 'h14 : 'h1C);
      step(($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00,
           ($urandom_range(0, 2) == 0), a, int'($urandom));
    end
    step(2'b00, 0, 'h00, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule